// File: doc/BRIEF.md
# Watermark FIFO for Segment Words

This block is a single-clock first-in first-out buffer for segment data words. A producer pushes words through a valid/ready write port. A consumer takes them from a valid/ready read port. The oldest stored word is always visible on the read data bus whenever the read side is valid.

Besides full and empty, the block produces two flow-control flags from levels that software sets. Both levels are counted in whole segment words. The "section available" flag rises once the stored word count reaches its level. It tells downstream logic that a useful chunk is ready. The "section space" flag is high while the fill is below its level and drops once the fill reaches it. It tells upstream logic to stop feeding. Both levels may change at any time.

Two fixed thresholds guard the edges of the buffer: almost-full at the depth minus four, and almost-empty at four words. A write to a full buffer and a read from an empty one are recorded in sticky error flags. Every flag is a register computed from the fill level that results after the current cycle's transfers.

Top module: `sect_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted. While `rd_valid` is high, `rd_data` shows the oldest stored word.
- R2: `full` is high exactly when DEPTH words are stored, and `empty` exactly when none are. `wr_ready` is the inverse of `full` and `rd_valid` is the inverse of `empty`.
- R3: In a cycle where a write and a read are both accepted, the fill level stays the same. The fill level never exceeds DEPTH.
- R4: `sect_avail` is high exactly when the stored word count is greater than or equal to `cfg_avail_lvl`.
- R5: `sect_space` is high exactly when the stored word count is below `cfg_space_lvl`. It is low at or above that level.
- R6: `almost_full` is high when at least DEPTH-4 words are stored. `almost_empty` is high when at most 4 words are stored.
- R7: A write offered while `full` is high is dropped. The stored contents and the fill level are unaffected by it, and `overflow` is set and stays set until reset.
- R8: A read requested while `empty` is high delivers nothing. `underflow` is set and stays set until reset.
- R9: A change of either configured level takes effect on the flags at the next clock edge, with no transfer needed.
- R10: During reset the flags read: `empty`=1, `almost_empty`=1, `sect_space`=1, and `full`, `almost_full`, `sect_avail`, `overflow`, `underflow` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | WORD_W | Word to store |
| wr_ready | output | 1 | A word can be accepted this cycle |
| rd_ready | input | 1 | Consumer takes the visible word |
| rd_valid | output | 1 | A word is visible on rd_data |
| rd_data | output | WORD_W | Oldest stored word |
| cfg_avail_lvl | input | CNT_W | Section-available level in words |
| cfg_space_lvl | input | CNT_W | Section-space level in words |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No words stored |
| almost_full | output | 1 | At least DEPTH-4 words stored |
| almost_empty | output | 1 | At most 4 words stored |
| sect_avail | output | 1 | Fill at or above the available level |
| sect_space | output | 1 | Fill below the space level |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read was requested while empty |

## Verification
The bench builds the block with DEPTH=16 and 32-bit words. With that depth the buffer can be filled to the top and drained back to empty within a few dozen cycles. Every fill level is visited on the way, so the almost-full level (12), the almost-empty level (4) and each watermark edge are crossed in both directions. A dropped write at full, a read at empty, and level changes with no traffic are also within reach.

// File: rtl/sect_fifo_pkg.sv
package sect_fifo_pkg;

  // Fill level after one cycle: +1 for an accepted write, -1 for an accepted read.
  function automatic int unsigned step_fill(int unsigned fill, logic inc, logic dec);
    int unsigned r;
    r = fill;
    if (inc && !dec) r = fill + 1;
    if (dec && !inc) r = fill - 1;
    return r;
  endfunction

  // Low-watermark rule: data available once the fill reaches the level.
  function automatic logic reached(int unsigned fill, int unsigned lvl);
    return fill >= lvl;
  endfunction

  // High-watermark rule: space flag stays only while below the level.
  function automatic logic below(int unsigned fill, int unsigned lvl);
    return fill < lvl;
  endfunction

  // Pointer advance with wrap at the last slot.
  function automatic int unsigned wrap_inc(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/sect_fifo_mem.sv
module sect_fifo_mem #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 64,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  // Show-ahead read: the oldest word is visible without a request.
  assign rdata = slots[raddr];

endmodule

// File: rtl/sect_fifo_ctrl.sv
module sect_fifo_ctrl #(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             rd_ready,
  input  logic             full_q,
  input  logic             empty_q,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic             wr_drop,
  output logic             rd_bad,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] fill_q,
  output logic [CNT_W-1:0] fill_nxt,
  output logic             ovf_q,
  output logic             unf_q
);

  logic [PTR_W-1:0] wr_ptr_inc;
  logic [PTR_W-1:0] rd_ptr_inc;

  // Accept/reject decisions use the registered flags only.
  assign wr_fire = wr_valid && !full_q;
  assign wr_drop = wr_valid &&  full_q;
  assign rd_fire = rd_ready && !empty_q;
  assign rd_bad  = rd_ready &&  empty_q;

  // Pointer wrap: a power-of-two depth wraps by width, any other depth by compare.
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_ptr_inc = wr_ptr + 1'b1;
      assign rd_ptr_inc = rd_ptr + 1'b1;
    end else begin : g_any
      assign wr_ptr_inc = PTR_W'(sect_fifo_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      assign rd_ptr_inc = PTR_W'(sect_fifo_pkg::wrap_inc(int'(rd_ptr), DEPTH));
    end
  endgenerate

  assign fill_nxt = CNT_W'(sect_fifo_pkg::step_fill(int'(fill_q), wr_fire, rd_fire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr_inc;
      if (rd_fire) rd_ptr <= rd_ptr_inc;
      fill_q <= fill_nxt;
      if (wr_drop) ovf_q <= 1'b1;
      if (rd_bad)  unf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sect_fifo_flags.sv
module sect_fifo_flags #(
  parameter int DEPTH    = 64,
  parameter int AF_GAP   = 4,
  parameter int AE_LEVEL = 4,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_nxt,
  input  logic [CNT_W-1:0] cfg_avail_lvl,
  input  logic [CNT_W-1:0] cfg_space_lvl,
  output logic             full_q,
  output logic             empty_q,
  output logic             afull_q,
  output logic             aempty_q,
  output logic             avail_q,
  output logic             space_q
);

  localparam int AF_LVL = DEPTH - AF_GAP;

  logic full_d, empty_d, afull_d, aempty_d, avail_d, space_d;

  always_comb begin
    full_d   = sect_fifo_pkg::reached(int'(fill_nxt), DEPTH);
    empty_d  = !sect_fifo_pkg::reached(int'(fill_nxt), 1);
    afull_d  = sect_fifo_pkg::reached(int'(fill_nxt), AF_LVL);
    aempty_d = sect_fifo_pkg::below(int'(fill_nxt), AE_LEVEL + 1);
    avail_d  = sect_fifo_pkg::reached(int'(fill_nxt), int'(cfg_avail_lvl));
    space_d  = sect_fifo_pkg::below(int'(fill_nxt), int'(cfg_space_lvl));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
      afull_q  <= 1'b0;
      aempty_q <= 1'b1;
      avail_q  <= 1'b0;
      space_q  <= 1'b1;
    end else begin
      full_q   <= full_d;
      empty_q  <= empty_d;
      afull_q  <= afull_d;
      aempty_q <= aempty_d;
      avail_q  <= avail_d;
      space_q  <= space_d;
    end
  end

endmodule

// File: rtl/sect_fifo.sv
module sect_fifo #(
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 64,
  parameter int AF_GAP   = 4,
  parameter int AE_LEVEL = 4,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cfg_avail_lvl,
  input  logic [CNT_W-1:0]  cfg_space_lvl,
  output logic              full,
  output logic              empty,
  output logic              almost_full,
  output logic              almost_empty,
  output logic              sect_avail,
  output logic              sect_space,
  output logic              overflow,
  output logic              underflow
);

  // Named internal events, also used by the bound checker.
  logic             wr_fire, rd_fire, wr_drop, rd_bad;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill_q, fill_nxt;

  sect_fifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .rd_ready (rd_ready),
    .full_q   (full),
    .empty_q  (empty),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .wr_drop  (wr_drop),
    .rd_bad   (rd_bad),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .fill_q   (fill_q),
    .fill_nxt (fill_nxt),
    .ovf_q    (overflow),
    .unf_q    (underflow)
  );

  sect_fifo_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  sect_fifo_flags #(.DEPTH(DEPTH), .AF_GAP(AF_GAP), .AE_LEVEL(AE_LEVEL), .CNT_W(CNT_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .fill_nxt      (fill_nxt),
    .cfg_avail_lvl (cfg_avail_lvl),
    .cfg_space_lvl (cfg_space_lvl),
    .full_q        (full),
    .empty_q       (empty),
    .afull_q       (almost_full),
    .aempty_q      (almost_empty),
    .avail_q       (sect_avail),
    .space_q       (sect_space)
  );

  assign wr_ready = !full;
  assign rd_valid = !empty;

endmodule

// File: rtl/sect_fifo_chk.sv
module sect_fifo_chk #(
  parameter int DEPTH    = 64,
  parameter int AF_GAP   = 4,
  parameter int AE_LEVEL = 4,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             full,
  input logic             empty,
  input logic             almost_full,
  input logic             almost_empty,
  input logic             sect_avail,
  input logic             sect_space,
  input logic             overflow,
  input logic             underflow,
  input logic [CNT_W-1:0] cfg_avail_lvl,
  input logic [CNT_W-1:0] cfg_space_lvl,
  input logic [CNT_W-1:0] fill_q,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic             wr_drop,
  input logic             rd_bad
);

  // R2
  a_r2_full_stalls_writer: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_ready);
  a_r2_empty_hides_data: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_valid);

  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
  a_r3_pass_through_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(fill_q));

  // R4
  a_r4_empty_not_avail: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && $stable(cfg_avail_lvl) && cfg_avail_lvl != '0) |-> !sect_avail);

  // R5
  a_r5_full_no_space: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $stable(cfg_space_lvl) && int'(cfg_space_lvl) <= DEPTH) |-> !sect_space);

  // R6
  a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (DEPTH - AF_GAP > AE_LEVEL) |-> !(almost_full && almost_empty));

  // R7
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> overflow);
  a_r7_drop_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> !wr_fire);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8
  a_r8_bad_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> underflow);
  a_r8_bad_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> !rd_fire);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

endmodule

bind sect_fifo sect_fifo_chk #(
  .DEPTH(DEPTH), .AF_GAP(AF_GAP), .AE_LEVEL(AE_LEVEL), .CNT_W(CNT_W)
) u_sect_fifo_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .full          (full),
  .empty         (empty),
  .almost_full   (almost_full),
  .almost_empty  (almost_empty),
  .sect_avail    (sect_avail),
  .sect_space    (sect_space),
  .overflow      (overflow),
  .underflow     (underflow),
  .cfg_avail_lvl (cfg_avail_lvl),
  .cfg_space_lvl (cfg_space_lvl),
  .fill_q        (fill_q),
  .wr_fire       (wr_fire),
  .rd_fire       (rd_fire),
  .wr_drop       (wr_drop),
  .rd_bad        (rd_bad)
);

// File: tb/test_sect_fifo.sv
module test_sect_fifo;

  localparam int W  = 32;
  localparam int D  = 16;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          wr_ready;
  logic          rd_ready = 1'b0;
  logic          rd_valid;
  logic [W-1:0]  rd_data;
  logic [CW-1:0] cfg_avail_lvl = CW'(3);
  logic [CW-1:0] cfg_space_lvl = CW'(10);
  logic full, empty, almost_full, almost_empty, sect_avail, sect_space, overflow, underflow;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] q[$];
  logic exp_ovf = 1'b0;
  logic exp_unf = 1'b0;

  always #4ns clk = ~clk;

  sect_fifo #(.WORD_W(W), .DEPTH(D)) i_sect_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_avail_lvl(cfg_avail_lvl), .cfg_space_lvl(cfg_space_lvl),
    .full(full), .empty(empty), .almost_full(almost_full), .almost_empty(almost_empty),
    .sect_avail(sect_avail), .sect_space(sect_space),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: each accepted read must show the oldest expected word (R1).
  always @(posedge clk) begin
    if (rst_n && rd_ready && rd_valid) begin
      if (q.size() == 0) chk("R1 read with empty model", 32'd1, 32'd0);
      else begin
        chk("R1 read order", rd_data, q[0]);
        void'(q.pop_front());
      end
    end
  end

  // Whole flag set against the model fill level.
  task automatic check_flags(input string ph);
    int n;
    n = q.size();
    chk({ph, " R2 full"},          W'(full),         W'(n == D));
    chk({ph, " R2 empty"},         W'(empty),        W'(n == 0));
    chk({ph, " R2 wr_ready"},      W'(wr_ready),     W'(n != D));
    chk({ph, " R6 almost_full"},   W'(almost_full),  W'(n >= D - 4));
    chk({ph, " R6 almost_empty"},  W'(almost_empty), W'(n <= 4));
    chk({ph, " R4 sect_avail"},    W'(sect_avail),   W'(n >= int'(cfg_avail_lvl)));
    chk({ph, " R5 sect_space"},    W'(sect_space),   W'(n < int'(cfg_space_lvl)));
    chk({ph, " R7 overflow"},      W'(overflow),     W'(exp_ovf));
    chk({ph, " R8 underflow"},     W'(underflow),    W'(exp_unf));
    if (n > 0) chk({ph, " R1 head word"}, rd_data, q[0]);
  endtask

  // Driver: one cycle of stimulus, model update, then flag check.
  task automatic step(input logic wv, input logic [W-1:0] wd, input logic rr, input string ph);
    logic acc;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_ready = rr;
    acc = wv && wr_ready;
    if (wv && !wr_ready) exp_ovf = 1'b1;
    if (rr && !rd_valid) exp_unf = 1'b1;
    @(posedge clk);
    if (acc) q.push_back(wd);
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
    check_flags(ph);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 empty", W'(empty), 1);
    chk("R10 almost_empty", W'(almost_empty), 1);
    chk("R10 sect_space", W'(sect_space), 1);
    chk("R10 full", W'(full), 0);
    chk("R10 almost_full", W'(almost_full), 0);
    chk("R10 sect_avail", W'(sect_avail), 0);
    chk("R10 overflow", W'(overflow), 0);
    chk("R10 underflow", W'(underflow), 0);
    rst_n = 1'b1;

    // Fill to the top one word at a time: R2 R4 R5 R6 edges on the way up.
    for (int i = 0; i < D; i++) step(1'b1, 32'hA000_0000 + W'(i), 1'b0, "fill");

    // R7: write at full is dropped; fill and contents unchanged.
    step(1'b1, 32'hDEAD_BEEF, 1'b0, "R7 drop");
    step(1'b1, 32'hDEAD_BEE0, 1'b0, "R7 drop again");

    // Drain: monitor checks order (R1), flags checked each cycle on the way down.
    for (int i = 0; i < D; i++) step(1'b0, '0, 1'b1, "drain");

    // R8: read while empty.
    step(1'b0, '0, 1'b1, "R8 bad read");

    // R3: simultaneous read and write keeps fill at 5.
    cfg_avail_lvl = CW'(5);
    cfg_space_lvl = CW'(6);
    for (int i = 0; i < 5; i++) step(1'b1, 32'hB000_0000 + W'(i), 1'b0, "R3 prefill");
    for (int i = 0; i < 6; i++) step(1'b1, 32'hC000_0000 + W'(i), 1'b1, "R3 pass");
    chk("R3 fill held", W'(q.size()), 5);

    // R9: level changes with no traffic act at the next edge.
    @(negedge clk);
    cfg_avail_lvl = CW'(6);
    cfg_space_lvl = CW'(5);
    step(1'b0, '0, 1'b0, "R9 levels");
    chk("R9 sect_avail dropped", W'(sect_avail), 0);
    chk("R9 sect_space dropped", W'(sect_space), 0);
    cfg_avail_lvl = CW'(0);
    cfg_space_lvl = CW'(D);
    step(1'b0, '0, 1'b0, "R9 levels back");
    chk("R9 sect_avail raised", W'(sect_avail), 1);
    chk("R9 sect_space raised", W'(sect_space), 1);

    // Drain the rest, checking order.
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1, "final drain");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule